// File: doc/BRIEF.md
# Redundant Clock Source Selector

This block decides which clock source feeds the system. The candidates are two hot-swap oscillator modules, an internal margin oscillator, an external margin input, and a clock that arrives over a cable from a master backplane. The block sees only status signals. It does not touch a clock edge: the analog oscillators, the amplitude detectors and the glitch-free multiplexer sit outside it and act on its encoded choice.

The choice follows three layers. A detected master-backplane cable wins over everything else. If no cable is detected, a firmware select field can force either margin source. Otherwise the block fails over between the two oscillator modules on its own, and it keeps the module it is using for as long as that module stays healthy. When neither module is usable in automatic mode, it reports a separate fallback code, and the internal source then runs slightly below nominal.

For each module the block drives a green and a yellow LED, and it raises an alarm bit that names the failed module. Every raw status input passes through a two-flop synchronizer and a debounce filter before it can act.

Top module: `clk_src_sel`

## Requirements
- R1: A module is eligible only when its present and valid inputs are both high. Its green LED is lit exactly when it is eligible.
- R2: When exactly one module is eligible in automatic mode, `sel_src` selects that module. Code 0 means module 0 and code 1 means module 1.
- R3: When both modules become eligible and no module is yet in use, module 0 is selected and both green LEDs are lit.
- R4: A selected module stays selected while it is eligible. No switch is made when the other module recovers.
- R5: A present module with invalid amplitude lights its yellow LED with green off and sets its bit in `osc_alarm`. Selection moves to the other module if that module is eligible.
- R6: An absent module shows both LEDs off, and its alarm bit is clear.
- R7: A detected master-backplane input gives `sel_src` = 4, whatever the firmware field holds.
- R8: With no backplane input, `fw_sel` = 01 gives code 2 (internal margin) and `fw_sel` = 10 gives code 3 (external margin). The values 00 and 11 mean automatic mode.
- R9: In automatic mode with no eligible module, `sel_src` = 5 (fallback below nominal).
- R10: A change on a status input that lasts fewer than `DEB_CYCLES` clocks is ignored. A change that lasts longer reaches `sel_src` on the `DEB_CYCLES`+3rd rising edge after it was applied.
- R11: During reset, `sel_src` = 5 and all LEDs and alarms are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| mod_present | input | 2 | Module plugged in, one bit per module (asynchronous) |
| mod_valid | input | 2 | Module amplitude valid, one bit per module (asynchronous) |
| bp_detect | input | 1 | Master-backplane clock cable detected (asynchronous) |
| fw_sel | input | 2 | Firmware source choice, synchronous to `clk` |
| sel_src | output | 3 | Encoded selected source |
| led_green | output | 2 | Green LED drive per module |
| led_yellow | output | 2 | Yellow LED drive per module |
| osc_alarm | output | 2 | Failed-module alarm per module |

## Verification
The assertions hold on every cycle for the layered priority: the backplane override, the forced margin codes and the fallback code, each set against the filtered status the block uses internally. They also check that a module is never shown green and yellow at once, that a selected oscillator is always lit green, and that a move from module 0 to module 1 only happens after module 0 lost eligibility. Three behaviours depend on history, and only the bench scenarios can show them: that the block refuses to switch back, that a short glitch is swallowed, and the exact cycle in which a held change takes effect.

// File: rtl/clk_src_pkg.sv
package clk_src_pkg;

  typedef enum logic [2:0] {
    SRC_OSC0    = 3'd0,
    SRC_OSC1    = 3'd1,
    SRC_MRG_INT = 3'd2,
    SRC_MRG_EXT = 3'd3,
    SRC_BKPL    = 3'd4,
    SRC_FALLBK  = 3'd5
  } src_e;

  localparam logic [1:0] FW_MRG_INT = 2'b01;
  localparam logic [1:0] FW_MRG_EXT = 2'b10;

  // Layered priority: cable, then firmware, then automatic oscillator choice.
  function automatic src_e pick_src(input logic bp, input logic [1:0] fw,
                                    input logic have, input logic cur);
    if (bp)                     return SRC_BKPL;
    else if (fw == FW_MRG_INT)  return SRC_MRG_INT;
    else if (fw == FW_MRG_EXT)  return SRC_MRG_EXT;
    else if (!have)             return SRC_FALLBK;
    else if (cur)               return SRC_OSC1;
    else                        return SRC_OSC0;
  endfunction

endpackage

// File: rtl/clk_src_sync_deb.sv
module clk_src_sync_deb #(
  parameter int DEB_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(DEB_CYCLES + 1);

  logic          s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= 1'b0;
      s2   <= 1'b0;
      cnt  <= '0;
      dout <= 1'b0;
    end else begin
      s1 <= din;
      s2 <= s1;
      if (s2 != dout) begin
        if (cnt == CW'(DEB_CYCLES - 1)) begin
          dout <= s2;
          cnt  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/clk_src_filter.sv
module clk_src_filter #(
  parameter int WIDTH      = 5,
  parameter int DEB_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] clean
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    clk_src_sync_deb #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw[i]),
      .dout (clean[i])
    );
  end
endmodule

// File: rtl/clk_src_osc_arb.sv
module clk_src_osc_arb (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] elig,
  output logic       nxt_have,
  output logic       nxt_cur
);
  logic have_q, cur_q;

  // Keep the current module while it is eligible, else prefer module 0.
  always_comb begin
    if (have_q && elig[cur_q]) begin
      nxt_have = 1'b1;
      nxt_cur  = cur_q;
    end else if (elig[0]) begin
      nxt_have = 1'b1;
      nxt_cur  = 1'b0;
    end else if (elig[1]) begin
      nxt_have = 1'b1;
      nxt_cur  = 1'b1;
    end else begin
      nxt_have = 1'b0;
      nxt_cur  = cur_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      cur_q  <= 1'b0;
    end else begin
      have_q <= nxt_have;
      cur_q  <= nxt_cur;
    end
  end
endmodule

// File: rtl/clk_src_sel.sv
module clk_src_sel
  import clk_src_pkg::*;
#(
  parameter int DEB_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mod_present,
  input  logic [1:0] mod_valid,
  input  logic       bp_detect,
  input  logic [1:0] fw_sel,
  output logic [2:0] sel_src,
  output logic [1:0] led_green,
  output logic [1:0] led_yellow,
  output logic [1:0] osc_alarm
);
  localparam int NMOD = 2;
  localparam int NSTAT = 2 * NMOD + 1;

  logic [NSTAT-1:0] stat_raw, stat_clean;
  logic [NMOD-1:0]  pres_f, val_f, elig, bad;
  logic             bp_stable;
  logic             nxt_have, nxt_cur;
  src_e             sel_q;

  assign stat_raw = {bp_detect, mod_valid, mod_present};

  clk_src_filter #(.WIDTH(NSTAT), .DEB_CYCLES(DEB_CYCLES)) u_filt (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  (stat_raw),
    .clean(stat_clean)
  );

  assign pres_f    = stat_clean[NMOD-1:0];
  assign val_f     = stat_clean[2*NMOD-1:NMOD];
  assign bp_stable = stat_clean[NSTAT-1];
  assign elig      = pres_f & val_f;
  assign bad       = pres_f & ~val_f;

  clk_src_osc_arb u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .elig    (elig),
    .nxt_have(nxt_have),
    .nxt_cur (nxt_cur)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q      <= SRC_FALLBK;
      led_green  <= '0;
      led_yellow <= '0;
      osc_alarm  <= '0;
    end else begin
      sel_q      <= pick_src(bp_stable, fw_sel, nxt_have, nxt_cur);
      led_green  <= elig;
      led_yellow <= bad;
      osc_alarm  <= bad;
    end
  end

  assign sel_src = sel_q;
endmodule

// File: rtl/clk_src_sel_chk.sv
module clk_src_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bp_stable,
  input logic [1:0] elig,
  input logic [1:0] fw_sel,
  input logic [2:0] sel_src,
  input logic [1:0] led_green,
  input logic [1:0] led_yellow
);
  p_bkpl_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bp_stable |=> sel_src == 3'd4);

  p_fw_int_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!bp_stable && fw_sel == 2'b01) |=> sel_src == 3'd2);

  p_fw_ext_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!bp_stable && fw_sel == 2'b10) |=> sel_src == 3'd3);

  p_fallback_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bp_stable && (fw_sel == 2'b00 || fw_sel == 2'b11) && elig == 2'b00)
      |=> sel_src == 3'd5);

  p_led_excl0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({led_green[0], led_yellow[0]}));

  p_led_excl1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({led_green[1], led_yellow[1]}));

  p_sel_lit0_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sel_src == 3'd0 |-> led_green[0]);

  p_sel_lit1_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_src == 3'd1 |-> led_green[1]);

  p_no_needless_swap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_src == 3'd1 && $past(sel_src) == 3'd0) |-> !led_green[0]);
endmodule

bind clk_src_sel clk_src_sel_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bp_stable (bp_stable),
  .elig      (elig),
  .fw_sel    (fw_sel),
  .sel_src   (sel_src),
  .led_green (led_green),
  .led_yellow(led_yellow)
);

// File: tb/clk_src_sel_bench.sv
module clk_src_sel_bench;
  localparam int DEB = 4;
  localparam int NVEC = 12;
  localparam int SETTLE = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mod_present = '0, mod_valid = '0, fw_sel = '0;
  logic       bp_detect = 1'b0;
  logic [2:0] sel_src;
  logic [1:0] led_green, led_yellow, osc_alarm;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  clk_src_sel #(.DEB_CYCLES(DEB)) u_clk_src_sel (
    .clk, .rst_n, .mod_present, .mod_valid, .bp_detect, .fw_sel,
    .sel_src, .led_green, .led_yellow, .osc_alarm
  );

  // {present, valid, bp, fw, expected sel, expected green, expected yellow}
  localparam logic [13:0] VEC [NVEC] = '{
    14'b11_11_0_00_000_11_00,  // R3 both eligible -> module 0
    14'b11_10_0_00_001_10_01,  // R5 module 0 invalid -> module 1
    14'b11_11_0_00_001_11_00,  // R4 module 0 recovers, stay on 1
    14'b10_10_0_00_001_10_00,  // R6 module 0 absent
    14'b01_01_0_00_000_01_00,  // R2 only module 0
    14'b11_01_0_01_010_01_10,  // R8 internal margin, R5 module 1 bad
    14'b11_01_0_10_011_01_10,  // R8 external margin
    14'b11_01_1_10_100_01_10,  // R7 cable beats firmware
    14'b11_01_1_00_100_01_10,  // R7 cable in auto mode
    14'b11_00_0_00_101_00_11,  // R9 none eligible
    14'b00_00_0_11_101_00_00,  // R6 R9 both absent, fw 11 auto
    14'b10_10_0_11_001_10_00   // R2 only module 1
  };

  task automatic check(input string req, input logic [2:0] es,
                       input logic [1:0] eg, input logic [1:0] ey);
    n_chk++;
    if (sel_src !== es || led_green !== eg || led_yellow !== ey || osc_alarm !== ey) begin
      n_bad++;
      $display("FAIL %s: sel=%0d green=%b yellow=%b alarm=%b, expected sel=%0d green=%b yellow=%b alarm=%b",
               req, sel_src, led_green, led_yellow, osc_alarm, es, eg, ey, ey);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    wait_cyc(3);
    check("R11 reset", 3'd5, 2'b00, 2'b00);
    mod_present = 2'b11; mod_valid = 2'b11;
    wait_cyc(3);
    check("R11 held in reset", 3'd5, 2'b00, 2'b00);
    rst_n = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      {mod_present, mod_valid, bp_detect, fw_sel} = VEC[v][13:7];
      wait_cyc(SETTLE);
      check($sformatf("vector %0d (R1..R9)", v), VEC[v][6:4], VEC[v][3:2], VEC[v][1:0]);
    end

    // R10: a glitch shorter than the debounce window is ignored
    mod_valid[1] = 1'b0;
    wait_cyc(DEB - 2);
    mod_valid[1] = 1'b1;
    wait_cyc(SETTLE);
    check("R10 short glitch ignored", 3'd1, 2'b10, 2'b00);

    // R10: a held change lands on edge DEB+3
    mod_valid[1] = 1'b0;
    for (int k = 0; k < DEB + 2; k++) @(posedge clk);
    @(negedge clk);
    check("R10 not yet applied", 3'd1, 2'b10, 2'b00);
    @(posedge clk);
    @(negedge clk);
    check("R10 applied on time", 3'd5, 2'b00, 2'b10);

    // R4: module 1 recovers while module 0 is eligible: stay on module 0
    mod_present = 2'b11; mod_valid = 2'b01;
    wait_cyc(SETTLE);
    check("R2 module 0 alone", 3'd0, 2'b01, 2'b10);
    mod_valid = 2'b11;
    wait_cyc(SETTLE);
    check("R4 keep module 0", 3'd0, 2'b11, 2'b00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 100000; k++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule